// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog built on a single down-counter. Software writes a soft-expiry count and sets the run bit. When that count runs out, the block raises an interrupt and enters an armed stage. An interrupt handler can then load a separate hard-margin count. If that second count also runs out, the block drives a system reset pulse of fixed length. A keep-alive has four steps: read the end-of-interrupt word, pause, reload the soft count and restart. This returns the block to the soft stage with the interrupt cleared.

The counter advances once per timer tick. A tick comes every `TICK_DIV` clock cycles while the counter runs. All bus accesses are single-cycle strobes. Read data appears on `busRdata` one clock after `busRd`. Writing zero to the control word stops everything, including a reset pulse already in progress.

Top module: `twostage_wdt`

## Requirements
- R1: After reset, every register reads 0, `irqOut` and `sysRstOut` are low, and reads of byte offsets other than 0x00, 0x04, 0x08, 0x0C and 0x10 return 0. The offsets hold: 0x00 load count, 0x04 live count, 0x08 control, 0x0C end-of-interrupt, 0x10 interrupt status.
- R2: The load count word (0x00) reads back all 32 bits exactly as written.
- R3: An enable edge copies the load count N into the counter and starts the soft stage. An enable edge is a control write with bit 0 set while control bit 0 is clear. Counting then decrements the counter once every `TICK_DIV` cycles. A tick that finds the counter at 0 is an expiry, so `irqOut` rises exactly (N+1)*`TICK_DIV` cycles after the enabling write.
- R4: Control value 0x2 (bit 0 clear, bit 1 set) pauses the counter and holds its value. A control write of 0x3 while bit 0 is already set does not reload the counter. A load write while the counter runs has no effect until the next enable edge.
- R5: A soft-stage expiry sets the interrupt and enters the armed stage. It also reloads the counter: with control bit 1 set, it reloads the start value captured at the last enable edge; with bit 1 clear, it reloads all ones.
- R6: Status (0x10) reads 1 while the interrupt is pending and 0 otherwise. A read of end-of-interrupt (0x0C) returns 0 and clears the interrupt.
- R7: An enable edge in the armed stage while the interrupt is still pending reloads the counter and keeps the armed stage. An expiry there drives `sysRstOut` high for exactly `RST_PULSE_LEN` cycles. Afterwards control reads 0 and the interrupt is clear.
- R8: An enable edge in the armed stage after the interrupt has been cleared returns the block to the soft stage. Its next expiry raises the interrupt again and does not reset.
- R9: A control write of 0 in any stage stops counting and returns the block to idle. This cancels both a pending reset and a reset pulse already under way: `sysRstOut` is low from the next cycle on.
- R10: While the timer has never been enabled, no interrupt and no reset occur, even with control set to 0x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWr | input | 1 | Write strobe |
| busWdata | input | DATA_W | Write data |
| busRd | input | 1 | Read strobe |
| busRdata | output | DATA_W | Read data, valid one cycle after the read strobe |
| irqOut | output | 1 | Soft-expiry interrupt, level |
| sysRstOut | output | 1 | System reset pulse |

## Verification
The hardest states to reach are the two enable edges in the armed stage: one with the interrupt still pending and one after it was cleared. They differ only in whether an end-of-interrupt read came first. Reaching them takes a soft expiry first. The bench waits on `irqOut` and then replays either the handler sequence or the keep-alive sequence through the bus. It measures the cycles until the next interrupt or reset edge. Cancelling a reset mid-pulse is reached the same way: the bench waits on `sysRstOut` and writes control 0 at once.

// File: rtl/wdt2s_pkg.sv
package wdt2s_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SOFT, ST_HARD, ST_RESET} wdStage_e;

  typedef struct packed {
    logic armLoad;    // enable edge: copy load word into counter
    logic expReload;  // soft expiry: reload counter
    logic countRun;   // counter may advance this cycle
  } wdStrobe_t;

  // consecutive 32-bit words, index = byte offset / 4
  localparam int NUM_REGS = 5;
  localparam int SEL_LOAD = 0;
  localparam int SEL_CUR  = 1;
  localparam int SEL_CTRL = 2;
  localparam int SEL_EOI  = 3;
  localparam int SEL_STAT = 4;
endpackage

// File: rtl/wdt2s_ctrl.sv
module wdt2s_ctrl
  import wdt2s_pkg::*;
#(
  parameter int PULSE_LEN = 16,
  localparam int PUL_W = $clog2(PULSE_LEN + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REGS-1:0] regSel,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [1:0]          wrCtrl,
  input  logic                tickIn,
  input  logic                cntZero,
  output wdStrobe_t           strobe,
  output logic [1:0]          ctrlOut,
  output logic                irqOut,
  output logic                sysRstOut
);
  wdStage_e stage, stageNxt;
  logic [1:0] ctrlReg;
  logic irqReg;
  logic [PUL_W-1:0] pulseCnt;
  logic ctrlWr, eoiRd, stopWr, active, enRise, expiry, resetEnd;

  always_comb begin
    ctrlWr = busWr && regSel[SEL_CTRL];
    eoiRd  = busRd && regSel[SEL_EOI];
    stopWr = ctrlWr && (wrCtrl == 2'b00);
    active = (stage == ST_SOFT) || (stage == ST_HARD);
    enRise = ctrlWr && wrCtrl[0] && !ctrlReg[0] && (stage != ST_RESET);
    strobe.countRun  = ctrlReg[0] && active && !(ctrlWr && !wrCtrl[0]);
    expiry           = strobe.countRun && tickIn && cntZero;
    strobe.armLoad   = enRise;
    strobe.expReload = expiry && (stage == ST_SOFT);
    resetEnd = (stage == ST_RESET) && (pulseCnt == PUL_W'(PULSE_LEN - 1)) && !stopWr;
  end

  always_comb begin
    stageNxt = stage;
    if (stopWr) stageNxt = ST_IDLE;
    else begin
      case (stage)
        ST_IDLE:  if (enRise) stageNxt = ST_SOFT;
        ST_SOFT:  if (expiry) stageNxt = ST_HARD;
                  else if (enRise) stageNxt = ST_SOFT;
        ST_HARD:  if (expiry) stageNxt = ST_RESET;
                  else if (enRise) stageNxt = irqReg ? ST_HARD : ST_SOFT;
        ST_RESET: if (resetEnd) stageNxt = ST_IDLE;
        default:  stageNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage    <= ST_IDLE;
      ctrlReg  <= 2'b00;
      irqReg   <= 1'b0;
      pulseCnt <= '0;
    end else begin
      stage <= stageNxt;
      if (resetEnd) ctrlReg <= 2'b00;
      else if (ctrlWr && ((stage != ST_RESET) || stopWr)) ctrlReg <= wrCtrl;
      if (strobe.expReload) irqReg <= 1'b1;
      else if (eoiRd || resetEnd) irqReg <= 1'b0;
      pulseCnt <= (stage == ST_RESET) ? pulseCnt + 1'b1 : '0;
    end
  end

  assign ctrlOut   = ctrlReg;
  assign irqOut    = irqReg;
  assign sysRstOut = (stage == ST_RESET);

  // R10
  irq_from_soft_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(stage) == ST_SOFT && $past(tickIn)));
  // R6
  eoi_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoiRd && !strobe.expReload) |=> !irqOut);
  // R7
  rst_from_hard_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstOut) |-> ($past(stage) == ST_HARD && $past(cntZero)));
  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sysRstOut) && !$past(stopWr)) |-> ($past(pulseCnt) == PUL_W'(PULSE_LEN - 1)));
  // R9
  stop_cancels_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> (!sysRstOut && !strobe.countRun));
endmodule

// File: rtl/wdt2s_dpath.sv
module wdt2s_dpath
  import wdt2s_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TICK_DIV = 4,
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REGS-1:0] regSel,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [DATA_W-1:0]   busWdata,
  input  wdStrobe_t           strobe,
  input  logic [1:0]          ctrlIn,
  input  logic                irqIn,
  output logic [DATA_W-1:0]   busRdata,
  output logic                tickOut,
  output logic                cntZero
);
  logic [DATA_W-1:0] loadReg, startVal, cntReg, rdReg;

  generate
    if (TICK_DIV == 1) begin : g_nodiv
      assign tickOut = strobe.countRun;
    end else begin : g_div
      logic [PRE_W-1:0] pre;
      assign tickOut = strobe.countRun && (pre == PRE_W'(TICK_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rstN || strobe.armLoad) pre <= '0;
        else if (strobe.countRun) pre <= tickOut ? '0 : pre + 1'b1;
      end
    end
  endgenerate

  assign cntZero = (cntReg == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadReg  <= '0;
      startVal <= '0;
      cntReg   <= '0;
      rdReg    <= '0;
    end else begin
      if (busWr && regSel[SEL_LOAD]) loadReg <= busWdata;
      if (strobe.armLoad) begin
        startVal <= loadReg;
        cntReg   <= loadReg;
      end else if (strobe.expReload) begin
        cntReg <= ctrlIn[1] ? startVal : '1;
      end else if (tickOut && !cntZero) begin
        cntReg <= cntReg - 1'b1;
      end
      if (busRd) begin
        rdReg <= '0;
        if (regSel[SEL_LOAD]) rdReg <= loadReg;
        if (regSel[SEL_CUR])  rdReg <= cntReg;
        if (regSel[SEL_CTRL]) rdReg <= {{(DATA_W-2){1'b0}}, ctrlIn};
        if (regSel[SEL_STAT]) rdReg <= {{(DATA_W-1){1'b0}}, irqIn};
      end
    end
  end

  assign busRdata = rdReg;

  // R4
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countRun && !strobe.armLoad && !strobe.expReload) |=> $stable(cntReg));
  // R3
  tick_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickOut && !cntZero && !strobe.armLoad && !strobe.expReload)
      |=> (cntReg == $past(cntReg) - DATA_W'(1)));
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import wdt2s_pkg::*;
#(
  parameter int ADDR_W        = 5,
  parameter int DATA_W        = 32,
  parameter int TICK_DIV      = 4,
  parameter int RST_PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              sysRstOut
);
  logic [NUM_REGS-1:0] regSel;
  wdStrobe_t strobe;
  logic [1:0] ctrlVal;
  logic tick, cntZero;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign regSel[g] = (busAddr == ADDR_W'(4 * g));
  end

  wdt2s_ctrl #(.PULSE_LEN(RST_PULSE_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .busWr(busWr), .busRd(busRd),
    .wrCtrl(busWdata[1:0]), .tickIn(tick), .cntZero(cntZero), .strobe(strobe),
    .ctrlOut(ctrlVal), .irqOut(irqOut), .sysRstOut(sysRstOut)
  );

  wdt2s_dpath #(.DATA_W(DATA_W), .TICK_DIV(TICK_DIV)) dpath_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .strobe(strobe), .ctrlIn(ctrlVal), .irqIn(irqOut),
    .busRdata(busRdata), .tickOut(tick), .cntZero(cntZero)
  );
endmodule

// File: tb/twostage_wdt_tb_top.sv
module twostage_wdt_tb_top;
  localparam int DIV = 2;
  localparam int PLEN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irqOut, sysRstOut;

  int checks = 0, fails = 0, cycles = 0;
  logic seenRst = 1'b0;

  always #4 clk = ~clk;

  twostage_wdt #(.ADDR_W(5), .DATA_W(32), .TICK_DIV(DIV), .RST_PULSE_LEN(PLEN)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRd(busRd), .busRdata(busRdata), .irqOut(irqOut), .sysRstOut(sysRstOut)
  );

  always @(negedge clk) if (sysRstOut) seenRst = 1'b1;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    while (!irqOut && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic waitRst(output int n);
    n = 0;
    while (!sysRstOut && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic clean();
    logic [31:0] d;
    wr(5'h08, 0);
    rd(5'h0C, d);
  endtask

  initial begin
    logic [31:0] d;
    int n;
    logic [31:0] pats [6] = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1234_0000, 32'h0000_FFFF, 32'h8000_0001};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state and map
    chk("R1 irq", {31'b0, irqOut}, 0);
    chk("R1 rst", {31'b0, sysRstOut}, 0);
    for (int a = 0; a < 8; a++) begin
      rd(5'(4 * a), d);
      chk("R1 reset read", d, 0);
    end

    // R2 readback sweep
    foreach (pats[i]) begin
      wr(5'h00, pats[i]);
      rd(5'h00, d);
      chk("R2 load readback", d, pats[i]);
    end
    wr(5'h00, 32'h0000_0077);
    rd(5'h14, d);
    chk("R1 unmapped read", d, 0);

    // R3 expiry timing sweep
    for (int nv = 0; nv < 6; nv++) begin
      clean();
      wr(5'h00, nv);
      wr(5'h08, 3);
      waitIrq(n);
      chk("R3 expiry cycles", n, (nv + 1) * DIV);
    end
    clean();

    // R4 pause holds count, sweep over pause instants
    for (int nv = 3; nv <= 6; nv += 3) begin
      for (int m = 0; m < (nv + 1) * DIV; m++) begin
        clean();
        wr(5'h00, nv);
        wr(5'h08, 3);
        repeat (m) @(negedge clk);
        wr(5'h08, 2);
        rd(5'h04, d);
        chk("R4 paused count", d, nv - m / DIV);
        repeat (3) @(negedge clk);
        rd(5'h04, d);
        chk("R4 count held", d, nv - m / DIV);
      end
    end
    // R4 rewrite of 0x3 while running: no reload
    clean();
    wr(5'h00, 10);
    wr(5'h08, 3);
    repeat (3) @(negedge clk);
    wr(5'h08, 3);
    repeat (2) @(negedge clk);
    wr(5'h08, 2);
    rd(5'h04, d);
    chk("R4 no reload on 3->3", d, 10 - 6 / DIV);
    // R4 load write while running deferred
    clean();
    wr(5'h00, 4);
    wr(5'h08, 3);
    wr(5'h00, 50);
    waitIrq(n);
    chk("R4 load deferred", n, (4 + 1) * DIV - 1);
    clean();

    // R5 reload with mode set and clear
    wr(5'h00, 5);
    wr(5'h08, 3);
    waitIrq(n);
    wr(5'h08, 0);
    rd(5'h04, d);
    chk("R5 mode1 reload", d, 5);
    clean();
    wr(5'h08, 1);
    waitIrq(n);
    wr(5'h08, 0);
    rd(5'h04, d);
    chk("R5 mode0 reload", d, 32'hFFFF_FFFF);
    clean();

    // R6 status and end-of-interrupt
    wr(5'h00, 2);
    wr(5'h08, 3);
    waitIrq(n);
    rd(5'h10, d);
    chk("R6 status pending", d, 1);
    rd(5'h0C, d);
    chk("R6 eoi data", d, 0);
    chk("R6 irq cleared", {31'b0, irqOut}, 0);
    rd(5'h10, d);
    chk("R6 status clear", d, 0);
    clean();

    // R7 handler path leads to reset pulse
    seenRst = 1'b0;
    wr(5'h00, 3);
    wr(5'h08, 3);
    waitIrq(n);
    wr(5'h08, 2);
    wr(5'h00, 4);
    wr(5'h08, 3);
    waitRst(n);
    chk("R7 hard expiry cycles", n, (4 + 1) * DIV);
    n = 0;
    while (sysRstOut && n < 100) begin n++; @(negedge clk); end
    chk("R7 pulse length", n, PLEN);
    chk("R7 irq cleared after reset", {31'b0, irqOut}, 0);
    rd(5'h08, d);
    chk("R7 ctrl cleared", d, 0);

    // R8 keep-alive in armed stage returns to soft
    seenRst = 1'b0;
    wr(5'h00, 3);
    wr(5'h08, 3);
    waitIrq(n);
    rd(5'h0C, d);
    wr(5'h08, 2);
    wr(5'h00, 5);
    wr(5'h08, 3);
    chk("R8 irq low after keepalive", {31'b0, irqOut}, 0);
    waitIrq(n);
    chk("R8 soft expiry again", n, (5 + 1) * DIV);
    chk("R8 no reset", {31'b0, seenRst}, 0);
    clean();

    // R9 stop in armed stage
    seenRst = 1'b0;
    wr(5'h00, 1);
    wr(5'h08, 3);
    waitIrq(n);
    wr(5'h08, 0);
    repeat (200) @(negedge clk);
    chk("R9 no reset after stop", {31'b0, seenRst}, 0);
    clean();
    // R9 stop during pulse
    wr(5'h00, 1);
    wr(5'h08, 3);
    waitIrq(n);
    wr(5'h08, 2);
    wr(5'h00, 1);
    wr(5'h08, 3);
    waitRst(n);
    wr(5'h08, 0);
    seenRst = 1'b0;
    chk("R9 pulse cut", {31'b0, sysRstOut}, 0);
    repeat (20) @(negedge clk);
    chk("R9 pulse stays off", {31'b0, seenRst}, 0);
    clean();

    // R10 never started
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    seenRst = 1'b0;
    wr(5'h00, 2);
    wr(5'h08, 2);
    repeat (100) @(negedge clk);
    chk("R10 no irq idle", {31'b0, irqOut}, 0);
    chk("R10 no reset idle", {31'b0, seenRst}, 0);
    rd(5'h04, d);
    chk("R10 count untouched", d, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule